// File: doc/BRIEF.md
# Speculative Retirement Queue

This block keeps the instructions of an out-of-order core in the order they were issued and lets them retire only from the oldest end. Issue takes a free slot and hands its index back as the result tag. Execution units later return results on a shared result bus under that tag. Each slot holds a kind (branch, store or register operation), a destination, a result value and status flags: done, mispredicted and faulted.

Dependent instructions can read a result by tag through parallel lookup ports in the span between completion and retirement. The oldest slot retires once it is done. A register operation drives a register-file write strobe, a store drives a memory write strobe, and a well-predicted branch just frees its slot. A mispredicted branch and a faulted instruction have no effect until they become the oldest slot. At that point the queue raises a one-cycle recovery pulse, writes nothing, and discards that slot and every younger one.

Top module: `spec_retire_queue`

## Requirements
- R1: After reset the queue is empty: `iss_ready` is 1, `iss_tag` is 0, and `retire`, `reg_we`, `mem_we`, `flush` and `fault` are 0.
- R2: An issue is taken when `iss_valid` and `iss_ready` are both 1. Tags come out consecutively modulo DEPTH in issue order. `iss_ready` is 0 while DEPTH slots are live and in a recovery cycle, and an issue offered then is dropped.
- R3: A writeback takes effect only if its tag names a live slot that is not yet done. It sets done and stores the value, the mispredict flag and the fault flag. Writebacks to dead or already-done slots change nothing.
- R4: Lookup port p reports hit 1 and the stored value when its tag names a live, done slot, and hit 0 otherwise.
- R5: `retire` is 1 exactly when the oldest live slot is done. `cm_tag`, `cm_dest` and `cm_value` then describe that slot. Slots retire strictly in issue order whatever the writeback order.
- R6: Kind encoding: 0 = branch, 1 = store, 2 = register operation. A retiring register operation without fault pulses `reg_we`. A retiring store without fault pulses `mem_we`, with `cm_dest` as the address and `cm_value` as the data.
- R7: A retiring branch with the mispredict flag clear writes nothing and frees its slot.
- R8: A retiring branch with the mispredict flag set and no fault raises `flush` for one cycle and writes nothing. The next cycle the queue is empty and `iss_tag` equals that branch's tag.
- R9: A fault flag has no visible effect until its slot is the oldest. It then raises `fault` (which takes precedence over any mispredict) with no write, and the queue is empty the next cycle.
- R10: After a recovery, a writeback carrying the tag of a discarded slot does not make that tag hit on a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_kind | input | 2 | Kind of the issued instruction |
| iss_dest | input | DEST_W | Register number or memory address |
| iss_ready | output | 1 | A slot can be taken this cycle |
| iss_tag | output | $clog2(DEPTH) | Tag given to the issue this cycle |
| wb_valid | input | 1 | Result bus valid |
| wb_tag | input | $clog2(DEPTH) | Slot the result belongs to |
| wb_value | input | DATA_W | Result value |
| wb_mispredict | input | 1 | Branch resolved against its prediction |
| wb_fault | input | 1 | Instruction raised an exception |
| look_tag | input | LOOKUPS*$clog2(DEPTH) | Packed lookup tags |
| look_hit | output | LOOKUPS | Lookup found a completed live slot |
| look_value | output | LOOKUPS*DATA_W | Packed lookup values |
| retire | output | 1 | Oldest slot leaves this cycle |
| cm_tag | output | $clog2(DEPTH) | Tag of the retiring slot |
| cm_dest | output | DEST_W | Destination of the retiring slot |
| cm_value | output | DATA_W | Value of the retiring slot |
| reg_we | output | 1 | Register-file write strobe |
| mem_we | output | 1 | Memory write strobe |
| flush | output | 1 | Misprediction recovery pulse |
| fault | output | 1 | Precise exception pulse |

## Verification
The hardest state to reach is a recovery at the oldest slot while the queue has wrapped, younger slots are already done, and a writeback for a younger slot is on the bus in the same cycle. Directed sequences build that state step by step: they fill the queue, complete younger entries out of order, then resolve the older branch or fault. Stale tags are then replayed at the result bus. A long random run with writebacks biased toward live slots and occasional mispredicts and faults repeats the situation at many pointer positions, compared every cycle against a bench model.

// File: rtl/srq_pkg.sv
package srq_pkg;
  typedef enum logic [1:0] {
    KIND_BRANCH = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_REGOP  = 2'd2
  } kind_e;

  typedef struct packed {
    logic  done;
    logic  mispred;
    logic  fault;
    kind_e kind;
  } ent_stat_t;
endpackage

// File: rtl/srq_ptrs.sv
module srq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_go,
  input  logic             retire_go,
  input  logic             kill,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic [DEPTH-1:0] live_mask
);
  localparam logic [IDX_W:0] ONE      = (IDX_W+1)'(1);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DEPTH);

  logic [IDX_W:0] head_q, head_d, tail_q, tail_d, count;
  logic           ptr_en;

  assign count    = tail_q - head_q;
  assign full     = (count == FULL_CNT);
  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign ptr_en   = kill | alloc_go | retire_go;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (kill) begin
      tail_d = head_q;
    end else begin
      if (alloc_go)  tail_d = tail_q + ONE;
      if (retire_go) head_d = head_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    logic [IDX_W-1:0] ofs;
    assign ofs          = IDX_W'(i) - head_idx;
    assign live_mask[i] = ({1'b0, ofs} < count);
  end

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  // R8
  kill_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (count == '0));
  // R8
  kill_holds_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> $stable(head_q));
endmodule

// File: rtl/srq_store.sv
module srq_store
  import srq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           alloc_go,
  input  logic [IDX_W-1:0]               alloc_idx,
  input  kind_e                          alloc_kind,
  input  logic [DEST_W-1:0]              alloc_dest,
  input  logic                           wb_go,
  input  logic [IDX_W-1:0]               wb_idx,
  input  logic [DATA_W-1:0]              wb_value,
  input  logic                           wb_mis,
  input  logic                           wb_flt,
  output ent_stat_t [DEPTH-1:0]          stat_q,
  output logic [DEPTH-1:0][DEST_W-1:0]   dest_q,
  output logic [DEPTH-1:0][DATA_W-1:0]   value_q
);
  ent_stat_t [DEPTH-1:0] stat_d;
  logic                  stat_en;

  assign stat_en = alloc_go | wb_go;

  always_comb begin
    stat_d = stat_q;
    if (alloc_go) begin
      stat_d[alloc_idx].done    = 1'b0;
      stat_d[alloc_idx].mispred = 1'b0;
      stat_d[alloc_idx].fault   = 1'b0;
      stat_d[alloc_idx].kind    = alloc_kind;
    end
    if (wb_go) begin
      stat_d[wb_idx].done    = 1'b1;
      stat_d[wb_idx].mispred = wb_mis;
      stat_d[wb_idx].fault   = wb_flt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_go) dest_q[alloc_idx] <= alloc_dest;
    if (wb_go)    value_q[wb_idx]   <= wb_value;
  end

  // R3
  wb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_go |-> !stat_q[wb_idx].done);
  // R2
  alloc_wb_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && wb_go) |-> (alloc_idx != wb_idx));
  // R3
  wb_marks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_go |=> stat_q[$past(wb_idx)].done);
endmodule

// File: rtl/srq_retire.sv
module srq_retire
  import srq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      head_live,
  input  ent_stat_t head_stat,
  output logic      retire,
  output logic      reg_we,
  output logic      mem_we,
  output logic      flush,
  output logic      fault,
  output logic      kill
);
  logic clean;

  assign retire = head_live & head_stat.done;
  assign fault  = retire & head_stat.fault;
  assign clean  = retire & ~head_stat.fault;
  assign flush  = clean & (head_stat.kind == KIND_BRANCH) & head_stat.mispred;
  assign reg_we = clean & (head_stat.kind == KIND_REGOP);
  assign mem_we = clean & (head_stat.kind == KIND_STORE);
  assign kill   = flush | fault;

  // R5
  commit_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, mem_we, flush, fault}));
  // R7
  branch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && head_stat.kind == KIND_BRANCH) |-> !(reg_we || mem_we));
  // R9
  fault_next_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !retire);
endmodule

// File: rtl/spec_retire_queue.sv
module spec_retire_queue
  import srq_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int DATA_W  = 32,
  parameter int DEST_W  = 16,
  parameter int LOOKUPS = 2,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      iss_valid,
  input  logic [1:0]                iss_kind,
  input  logic [DEST_W-1:0]         iss_dest,
  output logic                      iss_ready,
  output logic [IDX_W-1:0]          iss_tag,
  input  logic                      wb_valid,
  input  logic [IDX_W-1:0]          wb_tag,
  input  logic [DATA_W-1:0]         wb_value,
  input  logic                      wb_mispredict,
  input  logic                      wb_fault,
  input  logic [LOOKUPS*IDX_W-1:0]  look_tag,
  output logic [LOOKUPS-1:0]        look_hit,
  output logic [LOOKUPS*DATA_W-1:0] look_value,
  output logic                      retire,
  output logic [IDX_W-1:0]          cm_tag,
  output logic [DEST_W-1:0]         cm_dest,
  output logic [DATA_W-1:0]         cm_value,
  output logic                      reg_we,
  output logic                      mem_we,
  output logic                      flush,
  output logic                      fault
);
  logic [IDX_W-1:0]             head_idx, tail_idx;
  logic                         full, kill, alloc_go, wb_go;
  logic [DEPTH-1:0]             live_mask;
  ent_stat_t [DEPTH-1:0]        stat_q;
  logic [DEPTH-1:0][DEST_W-1:0] dest_q;
  logic [DEPTH-1:0][DATA_W-1:0] value_q;

  assign iss_ready = ~full & ~kill;
  assign alloc_go  = iss_valid & iss_ready;
  assign iss_tag   = tail_idx;
  assign wb_go     = wb_valid & live_mask[wb_tag] & ~stat_q[wb_tag].done & ~kill;
  assign cm_tag    = head_idx;
  assign cm_dest   = dest_q[head_idx];
  assign cm_value  = value_q[head_idx];

  srq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_go  (alloc_go),
    .retire_go (retire),
    .kill      (kill),
    .head_idx  (head_idx),
    .tail_idx  (tail_idx),
    .full      (full),
    .live_mask (live_mask)
  );

  srq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_go   (alloc_go),
    .alloc_idx  (tail_idx),
    .alloc_kind (kind_e'(iss_kind)),
    .alloc_dest (iss_dest),
    .wb_go      (wb_go),
    .wb_idx     (wb_tag),
    .wb_value   (wb_value),
    .wb_mis     (wb_mispredict),
    .wb_flt     (wb_fault),
    .stat_q     (stat_q),
    .dest_q     (dest_q),
    .value_q    (value_q)
  );

  srq_retire u_retire (
    .clk       (clk),
    .rst_n     (rst_n),
    .head_live (live_mask[head_idx]),
    .head_stat (stat_q[head_idx]),
    .retire    (retire),
    .reg_we    (reg_we),
    .mem_we    (mem_we),
    .flush     (flush),
    .fault     (fault),
    .kill      (kill)
  );

  for (genvar p = 0; p < LOOKUPS; p++) begin : g_look
    logic [IDX_W-1:0] t;
    assign t                              = look_tag[p*IDX_W +: IDX_W];
    assign look_hit[p]                    = live_mask[t] & stat_q[t].done;
    assign look_value[p*DATA_W +: DATA_W] = value_q[t];
  end

  // R8
  flush_rewinds_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (iss_tag == $past(cm_tag)));
  // R2
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !iss_ready);
  // R9
  fault_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(reg_we || mem_we || flush));
endmodule

// File: tb/spec_retire_queue_tb.sv
module spec_retire_queue_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int DATA_W     = 32;
  localparam int DEST_W     = 16;
  localparam int LOOKUPS    = 2;
  localparam int IDX_W      = $clog2(DEPTH);

  logic                      clk, rst_n;
  logic                      iss_valid;
  logic [1:0]                iss_kind;
  logic [DEST_W-1:0]         iss_dest;
  logic                      iss_ready;
  logic [IDX_W-1:0]          iss_tag;
  logic                      wb_valid;
  logic [IDX_W-1:0]          wb_tag;
  logic [DATA_W-1:0]         wb_value;
  logic                      wb_mispredict, wb_fault;
  logic [LOOKUPS*IDX_W-1:0]  look_tag;
  logic [LOOKUPS-1:0]        look_hit;
  logic [LOOKUPS*DATA_W-1:0] look_value;
  logic                      retire;
  logic [IDX_W-1:0]          cm_tag;
  logic [DEST_W-1:0]         cm_dest;
  logic [DATA_W-1:0]         cm_value;
  logic                      reg_we, mem_we, flush, fault;

  spec_retire_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .LOOKUPS(LOOKUPS)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_kind(iss_kind), .iss_dest(iss_dest),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
    .wb_mispredict(wb_mispredict), .wb_fault(wb_fault),
    .look_tag(look_tag), .look_hit(look_hit), .look_value(look_value),
    .retire(retire), .cm_tag(cm_tag), .cm_dest(cm_dest), .cm_value(cm_value),
    .reg_we(reg_we), .mem_we(mem_we), .flush(flush), .fault(fault)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // bench model of the queue
  int                m_kind [DEPTH];
  logic [DEST_W-1:0] m_dest [DEPTH];
  logic [DATA_W-1:0] m_val  [DEPTH];
  bit                m_done [DEPTH];
  bit                m_mis  [DEPTH];
  bit                m_flt  [DEPTH];
  int                m_head, m_cnt;
  int                n_chk, n_fail;

  task automatic chk(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic bit m_live(int t);
    return ((t - m_head + DEPTH) % DEPTH) < m_cnt;
  endfunction
  function automatic bit m_retire();
    return (m_cnt > 0) && m_done[m_head];
  endfunction
  function automatic bit m_kill();
    return m_retire() && (m_flt[m_head] || (m_kind[m_head] == 0 && m_mis[m_head]));
  endfunction

  task automatic compare();
    int h;
    bit r, f;
    int k;
    h = m_head;
    r = m_retire();
    chk("R2", "iss_ready", iss_ready, (m_cnt < DEPTH) && !m_kill());
    chk("R2", "iss_tag", iss_tag, (m_head + m_cnt) % DEPTH);
    chk("R5", "retire", retire, r);
    if (r) begin
      f = m_flt[h];
      k = m_kind[h];
      chk("R5", "cm_tag", cm_tag, h);
      chk(k == 0 ? "R7" : "R6", "reg_we", reg_we, !f && k == 2);
      chk(k == 0 ? "R7" : "R6", "mem_we", mem_we, !f && k == 1);
      if (!f && (k == 1 || k == 2)) begin
        chk("R6", "cm_dest", cm_dest, m_dest[h]);
        chk("R6", "cm_value", cm_value, m_val[h]);
      end
      chk("R8", "flush", flush, !f && k == 0 && m_mis[h]);
      chk("R9", "fault", fault, f);
    end else begin
      chk("R5", "idle reg_we", reg_we, 0);
      chk("R5", "idle mem_we", mem_we, 0);
      chk("R8", "idle flush", flush, 0);
      chk("R9", "idle fault", fault, 0);
    end
    for (int p = 0; p < LOOKUPS; p++) begin
      int t;
      bit eh;
      t  = int'(look_tag[p*IDX_W +: IDX_W]);
      eh = m_live(t) && m_done[t];
      chk("R4", "look_hit", look_hit[p], eh);
      if (eh) chk("R4", "look_value", look_value[p*DATA_W +: DATA_W], m_val[t]);
    end
  endtask

  task automatic model_update();
    bit r, acc;
    int s, t;
    r = m_retire();
    if (m_kill()) begin
      m_cnt = 0;
    end else begin
      t = int'(wb_tag);
      if (wb_valid && m_live(t) && !m_done[t]) begin
        m_done[t] = 1; m_val[t] = wb_value; m_mis[t] = wb_mispredict; m_flt[t] = wb_fault;
      end
      acc = iss_valid && (m_cnt < DEPTH);
      if (acc) begin
        s = (m_head + m_cnt) % DEPTH;
        m_kind[s] = int'(iss_kind); m_dest[s] = iss_dest;
        m_done[s] = 0; m_mis[s] = 0; m_flt[s] = 0;
      end
      if (r) begin
        m_head = (m_head + 1) % DEPTH;
        m_cnt--;
      end
      if (acc) m_cnt++;
    end
  endtask

  // called at a falling edge with inputs set; returns at the next falling edge
  task automatic cyc();
    #1 compare();
    @(posedge clk);
    #0 model_update();
    @(negedge clk);
  endtask

  task automatic drive(bit iv, int ik, int id, bit wv, int wt, int wval, bit wm, bit wf, int l0, int l1);
    iss_valid = iv; iss_kind = 2'(ik); iss_dest = DEST_W'(id);
    wb_valid = wv; wb_tag = IDX_W'(wt); wb_value = DATA_W'(wval);
    wb_mispredict = wm; wb_fault = wf;
    look_tag = {IDX_W'(l1), IDX_W'(l0)};
    cyc();
  endtask

  task automatic issue(int kind, int dest);
    drive(1, kind, dest, 0, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic wb(int tag, int val, bit mis, bit flt);
    drive(0, 0, 0, 1, tag, val, mis, flt, tag, 0);
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, i % DEPTH, (i + 3) % DEPTH);
  endtask

  int  b_tag, y_tag;

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; m_head = 0; m_cnt = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_kind[i] = 0; m_dest[i] = '0; m_val[i] = '0; m_done[i] = 0; m_mis[i] = 0; m_flt[i] = 0;
    end
    void'($urandom(32'd20240611));
    iss_valid = 0; iss_kind = 0; iss_dest = 0; wb_valid = 0; wb_tag = 0;
    wb_value = 0; wb_mispredict = 0; wb_fault = 0; look_tag = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "iss_ready", iss_ready, 1);
    chk("R1", "iss_tag", iss_tag, 0);
    chk("R1", "retire", retire, 0);
    chk("R1", "strobes", {reg_we, mem_we, flush, fault}, 0);
    @(negedge clk);

    // R3: second writeback to a done slot is ignored
    issue(2, 'h11); issue(2, 'h12); issue(1, 'h13);
    wb(1, 'hAAAA, 0, 0);
    wb(1, 'hBBBB, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2);
    #1 chk("R3", "value after repeated writeback", look_value[0 +: DATA_W], 'hAAAA);
    wb(2, 'h2222, 0, 0);
    wb(0, 'h1000, 0, 0);
    idle(4);

    // R2: fill to DEPTH, refuse the next issue
    for (int i = 0; i < DEPTH; i++) issue(2, 'h40 + i);
    drive(1, 2, 'h99, 0, 0, 0, 0, 0, 0, 0);
    #1 chk("R2", "iss_ready when full", iss_ready, 0);
    // R5: complete newest first, retire in order
    for (int i = DEPTH - 1; i >= 0; i--) wb((m_head + i) % DEPTH, 'h500 + i, 0, 0);
    idle(DEPTH + 2);

    // R8 / R10: mispredicted branch with done younger entries
    issue(2, 'h21);
    b_tag = (m_head + m_cnt) % DEPTH;
    issue(0, 0);
    y_tag = (m_head + m_cnt) % DEPTH;
    issue(1, 'h23);
    issue(2, 'h24);
    wb(y_tag, 'h77, 0, 0);
    wb(b_tag, 0, 1, 0);
    wb((b_tag + DEPTH - 1) % DEPTH, 'h66, 0, 0);
    idle(3);
    chk("R8", "queue empty after flush", m_cnt, 0);
    wb(y_tag, 'h99, 0, 0);
    #1 chk("R10", "stale tag lookup", look_hit[0], 0);
    idle(2);

    // R9: fault recorded on a younger entry, raised only at the head
    issue(2, 'h31); issue(2, 'h32); issue(1, 'h33);
    wb((m_head + 1) % DEPTH, 'h5, 0, 1);
    #1 chk("R9", "fault hidden while older pending", fault, 0);
    wb((m_head + 2) % DEPTH, 'h6, 0, 0);
    wb(m_head, 'h4, 0, 0);
    idle(3);

    // R7: correctly predicted branch
    issue(0, 0);
    wb(m_head, 'h1, 0, 0);
    idle(2);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      bit iv, wv, wm, wf;
      int ik, wt;
      iv = ($urandom % 3) != 0;
      ik = $urandom % 3;
      wv = ($urandom % 4) != 0;
      if (m_cnt > 0 && ($urandom % 4) != 0) wt = (m_head + ($urandom % m_cnt)) % DEPTH;
      else wt = $urandom % DEPTH;
      wm = ($urandom % 8) == 0;
      wf = ($urandom % 32) == 0;
      drive(iv, ik, $urandom % 65536, wv, wt, $urandom, wm, wf, $urandom % DEPTH, $urandom % DEPTH);
    end
    for (int i = 0; i < 3 * DEPTH; i++) begin
      if (m_cnt > 0) wb(m_head, 'h3C, 0, 0);
      else idle(1);
    end
    chk("R5", "drained", m_cnt, 0);
    summary();
    $finish;
  end
endmodule